// File: doc/BRIEF.md
# UART Interrupt Pending and Error-Status Unit

This unit gathers the interrupt events of one serial port and turns them into a single interrupt line. Four sources feed it: received data, receive error, transmit, and modem status. Each source has a raw pending flag, a mask flag and a masked pending flag. Software reaches all three through a small register bus, and clears the two pending registers by writing ones to them. The unit also keeps a receive error status register. That register catches overrun, parity, framing and break events, and any one of those events also raises the receive-error source.

The receiver, the transmitter and the modem logic send single-cycle strobes into the unit. Software reads the masked pending register to learn which source needs service and writes ones back to acknowledge it. It reads the error status register to collect the error kinds, and that read empties the register. Register reads are combinational, so read data is valid in the same cycle as the read strobe.

Top module: `uart_irq_unit`

## Requirements
- R1: After reset all four mask bits are 1, and the raw pending, masked pending and error status registers are all 0, so `irq` is 0.
- R2: In the raw pending, masked pending and mask registers, bit 0 is received data, bit 1 is receive error, bit 2 is transmit and bit 3 is modem. The receive-error source fires when any of the four error strobes is high.
- R3: A raw pending bit becomes 1 on the cycle after its source event, whatever the mask holds.
- R4: A masked pending bit becomes 1 on the cycle after its source event only if that source's mask bit was 0 when the event arrived. Otherwise the masked pending bit stays unchanged.
- R5: Writing a 1 to a bit of the raw pending register (address 0) or of the masked pending register (address 1) clears that bit in that register only. Writing a 0 leaves the bit as it is.
- R6: When an event and a write-one clear hit the same bit in the same cycle, the bit ends up at 1.
- R7: The mask register (address 2) reads back the value last written to it. A 1 disables its source, and the value 1111 disables all four sources.
- R8: The error status register (address 3) sets bit 0 on overrun, bit 1 on parity error, bit 2 on framing error and bit 3 on break. Bits stay set until the register is read, and several bits can be set at once.
- R9: A read of address 3 returns the latched error bits and clears them at the next clock edge. An error strobe that arrives in the same cycle as the read is kept.
- R10: `irq` is 1 exactly when at least one masked pending bit is 1.
- R11: Writes to address 3 have no effect. Read data is 0 when `reg_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 raw pending, 1 masked pending, 2 mask, 3 error status |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Combinational read data |
| ev_rx_data | input | 1 | Received-data event strobe |
| ev_tx | input | 1 | Transmit event strobe |
| ev_modem | input | 1 | Modem-status event strobe |
| err_overrun | input | 1 | Overrun strobe |
| err_parity | input | 1 | Parity error strobe |
| err_frame | input | 1 | Framing error strobe |
| err_break | input | 1 | Break detect strobe |
| irq | output | 1 | Combined interrupt line |

## Verification
Two pairs of functions can meet in one cycle. The first is a source event and a write-one clear of the same pending bit. The second is an error strobe and the read that clears the error status register. The bench drives each pair together on purpose: a modem event alongside a write of 1 to bit 3 of the masked pending register, and a break strobe alongside a read of address 3. After each, it reads the registers back and expects the set to have won. A long randomized stretch then mixes events, clears, mask writes and reads, and a behavioural model checks every cycle against the outputs.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int NSRC = 4;
  localparam int ERRW = 4;
  localparam int AW   = 2;
  localparam int DW   = NSRC;

  localparam int SRC_RX    = 0;
  localparam int SRC_ERR   = 1;
  localparam int SRC_TX    = 2;
  localparam int SRC_MODEM = 3;

  typedef enum logic [AW-1:0] {
    A_SRCP = 2'd0,
    A_PEND = 2'd1,
    A_MASK = 2'd2,
    A_ERR  = 2'd3
  } uirq_addr_e;

  // Sticky bit with write-one clear; a set in the same cycle wins.
  function automatic logic w1c_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  // Error latch with clear-on-read; new strobes in the read cycle survive.
  function automatic logic [ERRW-1:0] rc_next(logic [ERRW-1:0] cur, logic rd_clr,
                                              logic [ERRW-1:0] set);
    return set | (rd_clr ? '0 : cur);
  endfunction
endpackage

// File: rtl/uirq_src_cell.sv
module uirq_src_cell
  import uirq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ev,
  input  logic masked,
  input  logic clr_src,
  input  logic clr_pnd,
  output logic src_q,
  output logic pnd_q
);
  logic pnd_set;
  assign pnd_set = ev & ~masked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q <= 1'b0;
      pnd_q <= 1'b0;
    end else begin
      src_q <= w1c_next(src_q, ev, clr_src);
      pnd_q <= w1c_next(pnd_q, pnd_set, clr_pnd);
    end
  end
endmodule

// File: rtl/uirq_err_status.sv
module uirq_err_status
  import uirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ERRW-1:0] strobes,
  input  logic            rd_clr,
  output logic [ERRW-1:0] stat,
  output logic            err_event
);
  assign err_event = |strobes;

  always_ff @(posedge clk) begin
    if (!rst_n) stat <= '0;
    else        stat <= rc_next(stat, rd_clr, strobes);
  end
endmodule

// File: rtl/uirq_regif.sv
module uirq_regif
  import uirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic            rd,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic [NSRC-1:0] src_pend,
  input  logic [NSRC-1:0] pend,
  input  logic [ERRW-1:0] err_stat,
  output logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] clr_src_vec,
  output logic [NSRC-1:0] clr_pnd_vec,
  output logic            err_rd_clr,
  output logic [DW-1:0]   rdata
);
  uirq_addr_e a;
  assign a = uirq_addr_e'(addr);

  assign clr_src_vec = (wr && a == A_SRCP) ? wdata[NSRC-1:0] : '0;
  assign clr_pnd_vec = (wr && a == A_PEND) ? wdata[NSRC-1:0] : '0;
  assign err_rd_clr  = rd && a == A_ERR;

  always_ff @(posedge clk) begin
    if (!rst_n)                mask <= '1;
    else if (wr && a == A_MASK) mask <= wdata[NSRC-1:0];
  end

  always_comb begin
    rdata = '0;
    if (rd) begin
      case (a)
        A_SRCP: rdata = src_pend;
        A_PEND: rdata = pend;
        A_MASK: rdata = mask;
        A_ERR:  rdata = err_stat;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/uart_irq_unit.sv
module uart_irq_unit
  import uirq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          ev_rx_data,
  input  logic          ev_tx,
  input  logic          ev_modem,
  input  logic          err_overrun,
  input  logic          err_parity,
  input  logic          err_frame,
  input  logic          err_break,
  output logic          irq
);
  logic [ERRW-1:0] err_strobes;
  logic [ERRW-1:0] err_stat;
  logic            err_event;
  logic            err_rd_clr;
  logic [NSRC-1:0] ev_vec;
  logic [NSRC-1:0] mask;
  logic [NSRC-1:0] src_pend;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] clr_src_vec;
  logic [NSRC-1:0] clr_pnd_vec;

  assign err_strobes = {err_break, err_frame, err_parity, err_overrun};

  always_comb begin
    ev_vec            = '0;
    ev_vec[SRC_RX]    = ev_rx_data;
    ev_vec[SRC_ERR]   = err_event;
    ev_vec[SRC_TX]    = ev_tx;
    ev_vec[SRC_MODEM] = ev_modem;
  end

  uirq_err_status u_err (
    .clk(clk), .rst_n(rst_n), .strobes(err_strobes), .rd_clr(err_rd_clr),
    .stat(err_stat), .err_event(err_event)
  );

  uirq_regif u_regif (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .src_pend(src_pend), .pend(pend), .err_stat(err_stat),
    .mask(mask), .clr_src_vec(clr_src_vec), .clr_pnd_vec(clr_pnd_vec),
    .err_rd_clr(err_rd_clr), .rdata(reg_rdata)
  );

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    uirq_src_cell u_cell (
      .clk(clk), .rst_n(rst_n), .ev(ev_vec[i]), .masked(mask[i]),
      .clr_src(clr_src_vec[i]), .clr_pnd(clr_pnd_vec[i]),
      .src_q(src_pend[i]), .pnd_q(pend[i])
    );
  end

  assign irq = |pend;
endmodule

// File: rtl/uirq_checker.sv
module uirq_checker
  import uirq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [NSRC-1:0] ev_vec,
  input logic [NSRC-1:0] mask,
  input logic [NSRC-1:0] src_pend,
  input logic [NSRC-1:0] pend,
  input logic [NSRC-1:0] clr_src_vec,
  input logic [NSRC-1:0] clr_pnd_vec,
  input logic [ERRW-1:0] err_strobes,
  input logic [ERRW-1:0] err_stat,
  input logic            err_rd_clr,
  input logic            irq
);
  p_mask_reset_r1: assert property (@(posedge clk) $rose(rst_n) |-> (mask == '1 && !irq));

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    p_src_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ev_vec[i] |=> src_pend[i]);
    p_pend_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_vec[i] && !mask[i]) |=> pend[i]);
    p_pend_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_vec[i] && mask[i] && !pend[i]) |=> !pend[i]);
    p_zero_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (src_pend[i] && !clr_src_vec[i]) |=> src_pend[i]);
    p_pend_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[i] && !clr_pnd_vec[i]) |=> pend[i]);
  end

  for (genvar k = 0; k < ERRW; k++) begin : g_err
    p_err_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_strobes[k] |=> err_stat[k]);
  end

  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rd_clr && err_strobes == '0) |=> (err_stat == '0));

  p_irq_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(ev_vec & ~mask) != '0));
endmodule

bind uart_irq_unit uirq_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ev_vec(ev_vec), .mask(mask), .src_pend(src_pend),
  .pend(pend), .clr_src_vec(clr_src_vec), .clr_pnd_vec(clr_pnd_vec),
  .err_strobes(err_strobes), .err_stat(err_stat), .err_rd_clr(err_rd_clr), .irq(irq)
);

// File: tb/tb_uart_irq_unit.sv
module tb_uart_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [3:0] reg_wdata = '0;
  logic [3:0] reg_rdata;
  logic       ev_rx_data = 1'b0, ev_tx = 1'b0, ev_modem = 1'b0;
  logic       err_overrun = 1'b0, err_parity = 1'b0, err_frame = 1'b0, err_break = 1'b0;
  logic       irq;

  int errors = 0, checks = 0;
  bit done = 1'b0;
  int m_srcp = 0, m_pend = 0, m_mask = 15, m_err = 0;

  always #2 clk = ~clk;

  uart_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_rx_data(ev_rx_data), .ev_tx(ev_tx),
    .ev_modem(ev_modem), .err_overrun(err_overrun), .err_parity(err_parity),
    .err_frame(err_frame), .err_break(err_break), .irq(irq)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int model_read(input int addr);
    case (addr)
      0: return m_srcp;
      1: return m_pend;
      2: return m_mask;
      default: return m_err;
    endcase
  endfunction

  // ev: bit0 rx data, bit2 tx, bit3 modem (bit1 unused); es: {break,frame,parity,overrun}
  task automatic cyc(input bit wr, input bit rd, input int addr, input int wd,
                     input int ev, input int es, input string tag);
    int evall;
    int np;
    reg_wr = wr; reg_rd = rd; reg_addr = addr[1:0]; reg_wdata = wd[3:0];
    ev_rx_data = ev[0]; ev_tx = ev[2]; ev_modem = ev[3];
    err_overrun = es[0]; err_parity = es[1]; err_frame = es[2]; err_break = es[3];
    #1;
    chk(tag, int'(reg_rdata), rd ? model_read(addr) : 0);
    @(posedge clk);
    evall = (ev & 'hD) | ((es & 15) != 0 ? 2 : 0);
    np = m_pend;
    for (int i = 0; i < 4; i++) begin
      if (wr && addr == 0 && wd[i]) m_srcp &= ~(1 << i);
      if (wr && addr == 1 && wd[i]) np &= ~(1 << i);
      if (evall[i]) m_srcp |= (1 << i);
      if (evall[i] && !m_mask[i]) np |= (1 << i);
    end
    m_pend = np;
    if (wr && addr == 2) m_mask = wd & 15;
    if (rd && addr == 3) m_err = 0;
    m_err |= es & 15;
    @(negedge clk);
    chk("R10 irq", int'(irq), m_pend != 0 ? 1 : 0);
  endtask

  task automatic rdr(input int addr, input string tag);
    cyc(0, 1, addr, 0, 0, 0, tag);
  endtask

  task automatic wrr(input int addr, input int d, input string tag);
    cyc(1, 0, addr, d, 0, 0, tag);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    rdr(0, "R1 srcp"); rdr(1, "R1 pend"); rdr(2, "R1 mask"); rdr(3, "R1 err");
    chk("R1 mask value", m_mask, 15);
    // R3 raw pending sets while masked, R4 masked pending does not
    cyc(0, 0, 0, 0, 1, 0, "R3 rx event masked");
    rdr(0, "R3 srcp bit0"); rdr(1, "R4 pend stays 0");
    // R7 unmask all, R2 tx lands on bit 2
    wrr(2, 0, "R7 unmask"); rdr(2, "R7 mask readback");
    cyc(0, 0, 0, 0, 4, 0, "R2 tx event");
    rdr(0, "R2 srcp bit2"); rdr(1, "R2 pend bit2");
    // R5 write zero no effect, write one clears only its register
    wrr(1, 0, "R5 write zero"); rdr(1, "R5 pend unchanged");
    wrr(0, 4, "R5 clear srcp bit2"); rdr(0, "R5 srcp cleared"); rdr(1, "R5 pend kept");
    wrr(1, 4, "R5 clear pend bit2"); rdr(1, "R10 pend cleared");
    // R8 error latch, R2 error source on bit 1
    cyc(0, 0, 0, 0, 0, 6, "R8 parity+frame");
    rdr(1, "R2 error source bit1");
    rdr(3, "R8 err value 6"); rdr(3, "R9 err cleared");
    // R9 strobe during read survives
    cyc(0, 0, 0, 0, 0, 1, "R8 overrun");
    cyc(0, 1, 3, 0, 0, 8, "R9 read with break");
    rdr(3, "R9 break kept");
    // R11 write to error register ignored
    cyc(0, 0, 0, 0, 0, 2, "R8 parity");
    wrr(3, 15, "R11 write err"); rdr(3, "R11 err unchanged");
    rdr(3, "R9 clear");
    // R6 set beats clear on same bit
    cyc(1, 0, 1, 8, 8, 0, "R6 modem with pend clear");
    rdr(1, "R6 pend bit3 set");
    cyc(1, 0, 0, 15, 8, 0, "R6 modem with srcp clear");
    rdr(0, "R6 srcp bit3 set");
    wrr(0, 15, "R5 clear all srcp"); wrr(1, 15, "R5 clear all pend");
    // R4/R7 only modem masked
    wrr(2, 8, "R7 mask modem");
    cyc(0, 0, 0, 0, 8, 0, "R4 modem masked");
    rdr(0, "R3 srcp modem"); rdr(1, "R4 pend no modem");
    cyc(0, 0, 0, 0, 13, 15, "R2 all events");
    rdr(1, "R2 pend three"); rdr(3, "R8 all errors");
    wrr(2, 15, "R7 mask all");
    cyc(0, 0, 0, 0, 13, 1, "R7 all masked");
    rdr(1, "R7 pend unchanged");
    // randomized mix
    for (int n = 0; n < 600; n++) begin
      int r;
      r = $urandom_range(0, 9);
      cyc(r == 0 || r == 1, r >= 7, $urandom_range(0, 3), $urandom_range(0, 15),
          ($urandom_range(0, 3) == 0) ? $urandom_range(0, 15) : 0,
          ($urandom_range(0, 5) == 0) ? $urandom_range(0, 15) : 0, "R6 random mix");
    end
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end
endmodule